// File: doc/BRIEF.md
# Xon/Xoff In-Band Flow Controller

This block performs character-level software flow control for one serial channel. Each received character is checked against four programmable control characters, the two "resume" characters and the two "pause" characters. The check uses either a single character or a pair of consecutive characters. A pause match raises a hold on the local transmitter, which the transmitter honours at its next character boundary. A resume match releases that hold. Matched control characters never reach the receive FIFO. Every other character is passed to the FIFO write port one cycle after it arrives.

On the outgoing side, the block watches the receive FIFO fill level against a selectable threshold. When the level rises above the threshold, it asks the transmitter to insert the pause character or characters ahead of the transmit FIFO. When the level falls back below the threshold, it asks for the resume character or characters. Only the low 5, 6, 7 or 8 bits selected by the word length take part in a comparison. A special-detect mode, usable only while flow control is off, flags arrivals of the second pause character but still stores them.

Top module: `xonxoff_flow_ctrl`

## Requirements
- R1: After reset the outputs are idle: `fifo_we`, `tx_suspend`, `ins_req` and `ctrl_flag` are 0. All four control-character registers are 0, so with single mode selected a received 0x00 pauses the transmitter and is not stored.
- R2: In single mode (`rx_mode`=01), a character equal to pause-1 sets `tx_suspend` in the next cycle and is not written to the FIFO. It also sets `ctrl_flag` when `flag_en`=1.
- R3: In single mode, a character equal to resume-1 clears `tx_suspend` and `ctrl_flag` and is not written to the FIFO. Pause-1 takes priority when the two characters are equal.
- R4: In double mode (`rx_mode`=10 or 11), pause-1 followed by pause-2 sets `tx_suspend`, and resume-1 followed by resume-2 clears it. Neither character of a matched pair is written.
- R5: In double mode, a first character that matches but is followed by a non-matching second character causes both characters to be written as data: the first one cycle after the second arrives, the second in the cycle after that.
- R6: Comparisons use only the low bits selected by `word_len` (00=5, 01=6, 10=7, 11=8 bits). Register bit 0 pairs with character bit 0.
- R7: With `rx_mode`=00 and `special_en`=1, a character equal to pause-2 is written to the FIFO and sets `ctrl_flag` (when `flag_en`=1). In any other mode, `special_en` has no effect.
- R8: With `tx_fc_en`=1, `ins_req` rises with the pause-1 character when `rx_level` exceeds the threshold chosen by `trig_sel` (0:1, 1:4, 2:8, 3:14). A level equal to the threshold does not trigger it. Only one request sequence is issued per upward crossing.
- R9: After a pause request, a level below the threshold issues one resume request sequence (resume-1, then resume-2 in double mode).
- R10: A pending insert character stays stable until `tx_boundary` is seen. In double mode, the second character of the pair (pause-2 or resume-2) follows at the next boundary.
- R11: `flag_ack` clears `ctrl_flag` without changing `tx_suspend`. With `flag_en`=0, a pause match suspends the transmitter but leaves the flag clear.
- R12: In single mode, an ordinary character is written unchanged with `fifo_we` one cycle after `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control-character register write strobe |
| cfg_sel | input | 2 | Register select: 0 resume-1, 1 resume-2, 2 pause-1, 3 pause-2 |
| cfg_wdata | input | 8 | Register write data |
| rx_mode | input | 2 | 00 off, 01 single, 1x double |
| special_en | input | 1 | Special-character detect (only with rx_mode 00) |
| tx_fc_en | input | 1 | Enables outgoing pause/resume requests |
| flag_en | input | 1 | Lets pause or special matches set ctrl_flag |
| word_len | input | 2 | Character length 5..8 bits |
| rx_valid | input | 1 | Received character strobe (never two cycles in a row) |
| rx_char | input | 8 | Received character |
| flag_ack | input | 1 | Clears ctrl_flag |
| rx_level | input | LVL_W | Receive FIFO fill level |
| trig_sel | input | 2 | Threshold select |
| tx_boundary | input | 1 | Transmitter is at a character boundary and takes ins_char |
| fifo_we | output | 1 | Receive FIFO write strobe |
| fifo_wdata | output | 8 | Receive FIFO write data |
| tx_suspend | output | 1 | Hold the transmitter after the current character |
| ins_req | output | 1 | A control character must be sent before FIFO data |
| ins_char | output | 8 | Control character to send |
| ctrl_flag | output | 1 | Pause or special match flag |

## Verification
A stale pair-tracking state shows up within two received characters. It appears as a missing or doubled FIFO write, or as a `tx_suspend` that does not move after a complete pair. A wrong outgoing state appears on `ins_req` one cycle after `rx_level` crosses the threshold: the request repeats while the level stays high, or it is missing on the return crossing. A broken insert index shows up as the wrong character at the second boundary of a double-mode sequence.

// File: rtl/xonxoff_pkg.sv
// Shared types and helpers for the in-band flow controller.
// Assumes an 8-bit character container; word length selects 5..8 low bits.
package xonxoff_pkg;

    localparam int CHAR_W = 8;

    localparam logic [1:0] MODE_OFF    = 2'b00;
    localparam logic [1:0] MODE_SINGLE = 2'b01;

    typedef struct packed {
        logic [CHAR_W-1:0] go1;
        logic [CHAR_W-1:0] go2;
        logic [CHAR_W-1:0] stop1;
        logic [CHAR_W-1:0] stop2;
    } ctrl_chars_t;

    // Mask of the bits that take part in a compare for a given word length.
    function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] wl);
        return {CHAR_W{1'b1}} >> (3'd3 - {1'b0, wl});
    endfunction

    // Masked equality of two characters.
    function automatic logic char_eq(input logic [CHAR_W-1:0] a,
                                     input logic [CHAR_W-1:0] b,
                                     input logic [1:0]        wl);
        return ((a ^ b) & len_mask(wl)) == '0;
    endfunction

endpackage

// File: rtl/xonxoff_regs.sv
// Holds the four programmable control characters (resume-1, resume-2,
// pause-1, pause-2). Assumes a single write port; all entries reset to 0.
module xonxoff_regs
    import xonxoff_pkg::*;
#(
    parameter int N_REGS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CHAR_W-1:0] cfg_wdata,
    output ctrl_chars_t       chars
);

    logic [CHAR_W-1:0] regs_q [N_REGS];

    for (genvar gi = 0; gi < N_REGS; gi++) begin : g_reg
        // Purpose: load one control character on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[gi] <= '0;
            end else if (cfg_we && (cfg_sel == 2'(gi))) begin
                regs_q[gi] <= cfg_wdata;
            end
        end
    end

    assign chars.go1   = regs_q[0];
    assign chars.go2   = regs_q[1];
    assign chars.stop1 = regs_q[2];
    assign chars.stop2 = regs_q[3];

endmodule

// File: rtl/xonxoff_rx_match.sv
// Receive-side matcher: compares incoming characters with the control
// characters in single or pair mode, drives the transmitter hold and the
// status flag, and forwards non-control characters to the FIFO write port.
// Assumes rx_valid never asserts in two consecutive cycles, which leaves a
// free cycle for the second write of a broken pair.
module xonxoff_rx_match
    import xonxoff_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_chars_t       chars,
    input  logic [1:0]        rx_mode,
    input  logic              special_en,
    input  logic              flag_en,
    input  logic [1:0]        word_len,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_char,
    input  logic              flag_ack,
    output logic              fifo_we,
    output logic [CHAR_W-1:0] fifo_wdata,
    output logic              tx_suspend,
    output logic              ctrl_flag
);

    logic              hit_stop1, hit_stop2, hit_go1, hit_go2;
    logic              pend_q, pend_stop_q, pend_go_q;
    logic [CHAR_W-1:0] pend_char_q;
    logic              hold_q;
    logic [CHAR_W-1:0] hold_char_q;
    logic              we_q;
    logic [CHAR_W-1:0] wdata_q;
    logic              susp_q, flag_q;
    logic              pair_mode;

    assign pair_mode = rx_mode[1];

    // Purpose: masked compares of the current character with each register.
    always_comb begin
        hit_stop1 = char_eq(rx_char, chars.stop1, word_len);
        hit_stop2 = char_eq(rx_char, chars.stop2, word_len);
        hit_go1   = char_eq(rx_char, chars.go1,   word_len);
        hit_go2   = char_eq(rx_char, chars.go2,   word_len);
    end

    // Purpose: match state machine, FIFO write generation, hold and flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= 1'b0;
            pend_stop_q <= 1'b0;
            pend_go_q   <= 1'b0;
            pend_char_q <= '0;
            hold_q      <= 1'b0;
            hold_char_q <= '0;
            we_q        <= 1'b0;
            wdata_q     <= '0;
            susp_q      <= 1'b0;
            flag_q      <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (hold_q) begin
                we_q    <= 1'b1;
                wdata_q <= hold_char_q;
                hold_q  <= 1'b0;
            end
            if (flag_ack) flag_q <= 1'b0;
            if (rx_mode == MODE_OFF) susp_q <= 1'b0;
            if (!pair_mode) pend_q <= 1'b0;

            if (rx_valid) begin
                if (rx_mode == MODE_OFF) begin
                    we_q    <= 1'b1;
                    wdata_q <= rx_char;
                    if (special_en && flag_en && hit_stop2) flag_q <= 1'b1;
                end else if (rx_mode == MODE_SINGLE) begin
                    if (hit_stop1) begin
                        susp_q <= 1'b1;
                        if (flag_en) flag_q <= 1'b1;
                    end else if (hit_go1) begin
                        susp_q <= 1'b0;
                        flag_q <= 1'b0;
                    end else begin
                        we_q    <= 1'b1;
                        wdata_q <= rx_char;
                    end
                end else if (!pend_q) begin
                    if (hit_stop1 || hit_go1) begin
                        pend_q      <= 1'b1;
                        pend_stop_q <= hit_stop1;
                        pend_go_q   <= hit_go1;
                        pend_char_q <= rx_char;
                    end else begin
                        we_q    <= 1'b1;
                        wdata_q <= rx_char;
                    end
                end else begin
                    pend_q <= 1'b0;
                    if (pend_stop_q && hit_stop2) begin
                        susp_q <= 1'b1;
                        if (flag_en) flag_q <= 1'b1;
                    end else if (pend_go_q && hit_go2) begin
                        susp_q <= 1'b0;
                        flag_q <= 1'b0;
                    end else begin
                        we_q        <= 1'b1;
                        wdata_q     <= pend_char_q;
                        hold_q      <= 1'b1;
                        hold_char_q <= rx_char;
                    end
                end
            end
        end
    end

    assign fifo_we    = we_q;
    assign fifo_wdata = wdata_q;
    assign tx_suspend = susp_q;
    assign ctrl_flag  = flag_q;

    AST_RX_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);  // R5

    AST_PAUSE_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_mode == MODE_SINGLE && hit_stop1) |=> (!fifo_we && tx_suspend));  // R2

    AST_RESUME_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_mode == MODE_SINGLE && !hit_stop1 && hit_go1) |=> (!fifo_we && !tx_suspend));  // R3

    AST_SPECIAL_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_mode == MODE_OFF) |=> (fifo_we && fifo_wdata == $past(rx_char)));  // R7

    AST_FLAG_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_ack && !rx_valid) |=> !ctrl_flag);  // R11

endmodule

// File: rtl/xonxoff_tx_req.sv
// Transmit-side requester: compares the receive FIFO level with the chosen
// threshold and asks the transmitter to insert pause or resume characters,
// once per crossing. Assumes the transmitter takes ins_char in any cycle
// where ins_req and tx_boundary are both high.
module xonxoff_tx_req
    import xonxoff_pkg::*;
#(
    parameter int LVL_W  = 5,
    parameter int TRIG_0 = 1,
    parameter int TRIG_1 = 4,
    parameter int TRIG_2 = 8,
    parameter int TRIG_3 = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_chars_t       chars,
    input  logic              tx_fc_en,
    input  logic              pair_mode,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [1:0]        trig_sel,
    input  logic              tx_boundary,
    output logic              ins_req,
    output logic [CHAR_W-1:0] ins_char
);

    logic [LVL_W-1:0] trig;
    logic [1:0]       left_q;
    logic             idx_q;
    logic             send_stop_q;
    logic             remote_off_q;
    logic [1:0]       seq_len;

    // Purpose: threshold chosen by the select field.
    always_comb begin
        unique case (trig_sel)
            2'd0:    trig = LVL_W'(TRIG_0);
            2'd1:    trig = LVL_W'(TRIG_1);
            2'd2:    trig = LVL_W'(TRIG_2);
            default: trig = LVL_W'(TRIG_3);
        endcase
        seq_len = pair_mode ? 2'd2 : 2'd1;
    end

    // Purpose: start a sequence on a crossing and step it at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q       <= 2'd0;
            idx_q        <= 1'b0;
            send_stop_q  <= 1'b0;
            remote_off_q <= 1'b0;
        end else if (!tx_fc_en) begin
            left_q       <= 2'd0;
            remote_off_q <= 1'b0;
        end else if (left_q != 2'd0) begin
            if (tx_boundary) begin
                left_q <= left_q - 2'd1;
                idx_q  <= 1'b1;
            end
        end else if (!remote_off_q && (rx_level > trig)) begin
            left_q       <= seq_len;
            idx_q        <= 1'b0;
            send_stop_q  <= 1'b1;
            remote_off_q <= 1'b1;
        end else if (remote_off_q && (rx_level < trig)) begin
            left_q       <= seq_len;
            idx_q        <= 1'b0;
            send_stop_q  <= 1'b0;
            remote_off_q <= 1'b0;
        end
    end

    assign ins_req  = (left_q != 2'd0);
    assign ins_char = idx_q ? (send_stop_q ? chars.stop2 : chars.go2)
                            : (send_stop_q ? chars.stop1 : chars.go1);

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_req && !tx_boundary && tx_fc_en) |=> (ins_req && $stable(ins_char)));  // R10

    AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_fc_en |=> !ins_req);  // R8

    AST_START_ON_CROSSING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ins_req) |-> ($past(rx_level) != $past(trig)));  // R8

endmodule

// File: rtl/xonxoff_flow_ctrl.sv
// Top of the in-band flow controller for one channel: register bank,
// receive matcher and outgoing request generator.
// Assumes rx_valid is at least one idle cycle apart and rx_level never
// exceeds FIFO_DEPTH.
module xonxoff_flow_ctrl
    import xonxoff_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int TRIG_0     = 1,
    parameter int TRIG_1     = 4,
    parameter int TRIG_2     = 8,
    parameter int TRIG_3     = 14,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [7:0]        cfg_wdata,
    input  logic [1:0]        rx_mode,
    input  logic              special_en,
    input  logic              tx_fc_en,
    input  logic              flag_en,
    input  logic [1:0]        word_len,
    input  logic              rx_valid,
    input  logic [7:0]        rx_char,
    input  logic              flag_ack,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [1:0]        trig_sel,
    input  logic              tx_boundary,
    output logic              fifo_we,
    output logic [7:0]        fifo_wdata,
    output logic              tx_suspend,
    output logic              ins_req,
    output logic [7:0]        ins_char,
    output logic              ctrl_flag
);

    ctrl_chars_t chars;

    xonxoff_regs #(.N_REGS(4)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .chars     (chars)
    );

    xonxoff_rx_match u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .chars      (chars),
        .rx_mode    (rx_mode),
        .special_en (special_en),
        .flag_en    (flag_en),
        .word_len   (word_len),
        .rx_valid   (rx_valid),
        .rx_char    (rx_char),
        .flag_ack   (flag_ack),
        .fifo_we    (fifo_we),
        .fifo_wdata (fifo_wdata),
        .tx_suspend (tx_suspend),
        .ctrl_flag  (ctrl_flag)
    );

    xonxoff_tx_req #(
        .LVL_W  (LVL_W),
        .TRIG_0 (TRIG_0),
        .TRIG_1 (TRIG_1),
        .TRIG_2 (TRIG_2),
        .TRIG_3 (TRIG_3)
    ) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .chars       (chars),
        .tx_fc_en    (tx_fc_en),
        .pair_mode   (rx_mode[1]),
        .rx_level    (rx_level),
        .trig_sel    (trig_sel),
        .tx_boundary (tx_boundary),
        .ins_req     (ins_req),
        .ins_char    (ins_char)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(!rst_n) |-> (!fifo_we && !tx_suspend && !ins_req && !ctrl_flag));  // R1

endmodule

// File: tb/xonxoff_flow_ctrl_tb.sv
// Directed bench for the in-band flow controller.
module xonxoff_flow_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic [1:0] rx_mode = '0;
    logic       special_en = 1'b0;
    logic       tx_fc_en = 1'b0;
    logic       flag_en = 1'b0;
    logic [1:0] word_len = 2'b11;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_char = '0;
    logic       flag_ack = 1'b0;
    logic [4:0] rx_level = '0;
    logic [1:0] trig_sel = '0;
    logic       tx_boundary = 1'b0;
    logic       fifo_we, tx_suspend, ins_req, ctrl_flag;
    logic [7:0] fifo_wdata, ins_char;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int wr_cnt = 0;
    logic [7:0] wr_log [64];
    int ins_cnt = 0;
    logic [7:0] ins_log [64];

    xonxoff_flow_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rx_mode(rx_mode), .special_en(special_en),
        .tx_fc_en(tx_fc_en), .flag_en(flag_en), .word_len(word_len),
        .rx_valid(rx_valid), .rx_char(rx_char), .flag_ack(flag_ack),
        .rx_level(rx_level), .trig_sel(trig_sel), .tx_boundary(tx_boundary),
        .fifo_we(fifo_we), .fifo_wdata(fifo_wdata), .tx_suspend(tx_suspend),
        .ins_req(ins_req), .ins_char(ins_char), .ctrl_flag(ctrl_flag)
    );

    always #4 clk = ~clk;

    // Log FIFO writes and consumed insert characters at each edge.
    always @(posedge clk) begin
        if (rst_n) begin
            if (fifo_we) begin
                wr_log[wr_cnt % 64] <= fifo_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (ins_req && tx_boundary) begin
                ins_log[ins_cnt % 64] <= ins_char;
                ins_cnt <= ins_cnt + 1;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input logic [7:0] c);
        @(negedge clk);
        rx_valid = 1'b1; rx_char = c;
        @(negedge clk);
        rx_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic boundary();
        @(negedge clk);
        tx_boundary = 1'b1;
        @(negedge clk);
        tx_boundary = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 fifo_we after reset", fifo_we, 0);
        chk("R1 tx_suspend after reset", tx_suspend, 0);
        chk("R1 ins_req after reset", ins_req, 0);
        chk("R1 ctrl_flag after reset", ctrl_flag, 0);
        rx_mode = 2'b01;
        begin
            int w0 = wr_cnt;
            send(8'h00);
            chk("R1 zero register pauses", tx_suspend, 1);
            chk("R1 zero char not stored", wr_cnt - w0, 0);
        end
        cfg(2'd0, 8'h11); cfg(2'd1, 8'h12); cfg(2'd2, 8'h13); cfg(2'd3, 8'h14);
        send(8'h11);
        chk("R3 resume after reprogram", tx_suspend, 0);
    endtask

    task automatic t_single();
        int w0;
        rx_mode = 2'b01; flag_en = 1'b1; word_len = 2'b11;
        w0 = wr_cnt;
        send(8'h41);
        chk("R12 data written count", wr_cnt - w0, 1);
        chk("R12 data value", wr_log[w0 % 64], 8'h41);
        w0 = wr_cnt;
        send(8'h13);
        chk("R2 pause suspends", tx_suspend, 1);
        chk("R2 pause sets flag", ctrl_flag, 1);
        chk("R2 pause not stored", wr_cnt - w0, 0);
        send(8'h11);
        chk("R3 resume clears hold", tx_suspend, 0);
        chk("R3 resume clears flag", ctrl_flag, 0);
        chk("R3 resume not stored", wr_cnt - w0, 0);
    endtask

    task automatic t_wordlen();
        int w0;
        rx_mode = 2'b01; word_len = 2'b00;
        w0 = wr_cnt;
        send(8'hF3);
        chk("R6 5-bit compare pauses", tx_suspend, 1);
        send(8'hF1);
        chk("R6 5-bit compare resumes", tx_suspend, 0);
        chk("R6 masked chars not stored", wr_cnt - w0, 0);
        word_len = 2'b11;
        send(8'hF3);
        chk("R6 8-bit compare stores", wr_cnt - w0, 1);
        chk("R6 8-bit no pause", tx_suspend, 0);
    endtask

    task automatic t_flag();
        rx_mode = 2'b01; flag_en = 1'b0;
        send(8'h13);
        chk("R11 pause without flag_en", tx_suspend, 1);
        chk("R11 flag stays clear", ctrl_flag, 0);
        send(8'h11);
        flag_en = 1'b1;
        send(8'h13);
        chk("R11 flag set", ctrl_flag, 1);
        @(negedge clk); flag_ack = 1'b1;
        @(negedge clk); flag_ack = 1'b0;
        chk("R11 ack clears flag", ctrl_flag, 0);
        chk("R11 ack keeps hold", tx_suspend, 1);
        send(8'h11);
    endtask

    task automatic t_double();
        int w0;
        rx_mode = 2'b10;
        w0 = wr_cnt;
        send(8'h13);
        chk("R4 first half no pause", tx_suspend, 0);
        send(8'h14);
        chk("R4 pair pauses", tx_suspend, 1);
        send(8'h11); send(8'h12);
        chk("R4 pair resumes", tx_suspend, 0);
        chk("R4 pairs not stored", wr_cnt - w0, 0);
        send(8'h13); send(8'h55);
        chk("R5 broken pair writes two", wr_cnt - w0, 2);
        chk("R5 first in order", wr_log[w0 % 64], 8'h13);
        chk("R5 second in order", wr_log[(w0 + 1) % 64], 8'h55);
        chk("R5 broken pair no pause", tx_suspend, 0);
    endtask

    task automatic t_special();
        int w0;
        rx_mode = 2'b00; special_en = 1'b1; flag_en = 1'b1;
        w0 = wr_cnt;
        send(8'h14);
        chk("R7 special char stored", wr_cnt - w0, 1);
        chk("R7 special value", wr_log[w0 % 64], 8'h14);
        chk("R7 special flag", ctrl_flag, 1);
        chk("R7 special no pause", tx_suspend, 0);
        @(negedge clk); flag_ack = 1'b1;
        @(negedge clk); flag_ack = 1'b0;
        rx_mode = 2'b01;
        send(8'h14);
        chk("R7 ignored in single mode flag", ctrl_flag, 0);
        chk("R7 ignored in single mode stored", wr_cnt - w0, 2);
        special_en = 1'b0;
    endtask

    task automatic t_outgoing();
        int i0;
        rx_mode = 2'b01; tx_fc_en = 1'b1; trig_sel = 2'd1;
        i0 = ins_cnt;
        @(negedge clk); rx_level = 5'd4;
        @(negedge clk);
        chk("R8 level at threshold no request", ins_req, 0);
        rx_level = 5'd5;
        @(negedge clk);
        chk("R8 request above threshold", ins_req, 1);
        chk("R8 request char pause-1", ins_char, 8'h13);
        repeat (3) @(negedge clk);
        chk("R10 request held without boundary", ins_req, 1);
        chk("R10 nothing consumed without boundary", ins_cnt - i0, 0);
        boundary();
        chk("R10 consumed at boundary", ins_log[i0 % 64], 8'h13);
        chk("R10 request ends after one", ins_req, 0);
        rx_level = 5'd6;
        repeat (2) @(negedge clk);
        chk("R8 one request per crossing", ins_req, 0);
        rx_level = 5'd4;
        repeat (2) @(negedge clk);
        chk("R9 no resume at threshold", ins_req, 0);
        rx_level = 5'd3;
        @(negedge clk);
        chk("R9 resume request", ins_req, 1);
        chk("R9 resume char", ins_char, 8'h11);
        boundary();
        chk("R9 resume sent", ins_cnt - i0, 2);
        rx_mode = 2'b10; trig_sel = 2'd3;
        rx_level = 5'd15;
        @(negedge clk);
        chk("R8 double request", ins_req, 1);
        boundary();
        chk("R10 second char pending", ins_req, 1);
        chk("R10 second char pause-2", ins_char, 8'h14);
        boundary();
        chk("R10 double order first", ins_log[(i0 + 2) % 64], 8'h13);
        chk("R10 double order second", ins_log[(i0 + 3) % 64], 8'h14);
        chk("R10 double done", ins_req, 0);
        rx_level = 5'd0;
        @(negedge clk);
        boundary();
        boundary();
        chk("R9 double resume first", ins_log[(i0 + 4) % 64], 8'h11);
        chk("R9 double resume second", ins_log[(i0 + 5) % 64], 8'h12);
        tx_fc_en = 1'b0;
    endtask

    initial begin
        t_reset();
        t_single();
        t_wordlen();
        t_flag();
        t_double();
        t_special();
        t_outgoing();
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule